// File: doc/BRIEF.md
# SPI Serial Port with Sleep Handling

This block is an 8-bit SPI port. It can be a bus master that generates its own serial clock, or a slave that follows an external clock. Software sees three registers. The data buffer accepts the next byte to send and returns the last byte received. The control register holds the enable bit, the clock polarity, a 4-bit mode code and two sticky error flags. The status register holds the input-sample select, the clock-edge select and the buffer-full flag. Bytes move MSB first. A completion flag is raised after each byte, and a wake request can be generated from it.

Clock polarity sets the idle level of the serial clock. The edge-select bit works the opposite way to the usual phase bit. When it is set, data must be valid before the first clock edge of a bit and is captured on that first edge. When it is clear, data changes on the first edge and is captured on the second.

A sleep input models the core going to sleep while the module clock keeps running. A master freezes its transfer where it is and resumes it when sleep is released. A slave keeps taking bits from the pins. When its byte completes, it raises a wake request if the interrupt is enabled.

Top module: `spi_port`

## Requirements
- R1: After reset, the control register and status register read 0, the completion flag and wake request are low, and the SCK and SDO output enables are off.
- R2: In master mode, SCK idles at the polarity bit (control bit 4). With the edge-select bit (status bit 6) = 1, SDI is captured on the edge that leaves the idle level, and SDO changes on the edge that returns to it. With the edge-select bit = 0, SDO changes on the leaving edge and SDI is captured on the returning edge. Bits go out MSB first.
- R3: In master mode, with the sample-select bit (status bit 7) = 1, SDI is captured one half SCK period later than with it = 0.
- R4: Mode codes 0, 1 and 2 (control bits 3:0) make the port a master. The SCK half period is 2, 8 or 32 module clocks respectively.
- R5: When a byte completes, the received byte goes into the buffer, the buffer-full flag (status bit 0) sets and the completion flag sets. Reading the buffer clears buffer-full. Pulsing irq_clr clears the completion flag.
- R6: If a byte completes while buffer-full is set, the overflow flag (control bit 6) sets and the buffer keeps its old value.
- R7: A buffer write while a byte is in progress sets the collision flag (control bit 7). The write is ignored and the byte on the wire is unchanged.
- R8: While sleep is high, a master transfer freezes: SCK and SDO hold. After sleep is released, the transfer finishes with the correct data.
- R9: Mode codes 4 and 5 make the port a slave. It shifts on the external SCK with the same edge rules as R2, with SDI sampled at the normal point. The SCK half period must be at least 4 module clocks.
- R10: A slave completes bytes while sleep is high. wake_req is high exactly when sleep, irq_en and the completion flag are all high.
- R11: In mode 4, a high slave select turns off SDO and resets the bit position. In mode 5, slave select is ignored.
- R12: Clearing the enable bit (control bit 5) aborts a transfer. No completion follows, and both output enables go off.
- R13: A master drives SCK and SDO. A slave drives SDO only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low reset |
| sleep | input | 1 | Core sleep request |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_q | output | 8 | Control register value |
| stat_we | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data (bits 7:6 used) |
| stat_q | output | 8 | Status register value |
| buf_we | input | 1 | Buffer write strobe |
| buf_wdata | input | DW | Byte to transmit |
| buf_re | input | 1 | Buffer read strobe |
| buf_rdata | output | DW | Last received byte |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears completion flag |
| irq_flag | output | 1 | Completion flag |
| wake_req | output | 1 | Wake request to sleeping core |
| sck_i | input | 1 | Serial clock input (slave) |
| sck_o | output | 1 | Serial clock output (master) |
| sck_oe | output | 1 | Serial clock output enable |
| ss_n | input | 1 | Slave select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |

## Verification
The edge position counter, the shift registers and the flags are internal state, and a fault in any of them shows up at the ports within the byte it occurs in. A miscounted edge or a wrong phase shows up as a corrupted byte in the buffer or on SDO, or as a completion that never comes, by the end of that byte. Wrong sample timing is caught by a far-end model that launches data late, so a byte read at the wrong point comes back wrong. A stale bit position after slave deselect shows up as a collision on the next buffer write. A sleep fault shows up as SCK or SDO moving during sleep, or as no wake request after the slave byte.

// File: rtl/spi_port.sv
module spi_port #(
  parameter int DW = 8,
  parameter int SYNC = 2,
  parameter int HALF_FAST = 2,
  parameter int HALF_MID = 8,
  parameter int HALF_SLOW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  output logic [7:0]    ctrl_q,
  input  logic          stat_we,
  input  logic [7:0]    stat_wdata,
  output logic [7:0]    stat_q,
  input  logic          buf_we,
  input  logic [DW-1:0] buf_wdata,
  input  logic          buf_re,
  output logic [DW-1:0] buf_rdata,
  input  logic          irq_en,
  input  logic          irq_clr,
  output logic          irq_flag,
  output logic          wake_req,
  input  logic          sck_i,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          ss_n,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe
);
  localparam int EW = $clog2(2*DW + 2);
  localparam int PW = $clog2(HALF_SLOW);
  localparam logic [EW-1:0] NEDGE = EW'(2*DW);

  logic wcol, ovf, en, ckp, smp, cke, bf, busy, irq_q, sck_d;
  logic [3:0] mode;
  logic [DW-1:0] tx, rx, rx_nxt, buffer;
  logic [EW-1:0] hc, n, last;
  logic [PW-1:0] presc, half_m1;
  logic [SYNC-1:0] sck_sy, sdi_sy;
  logic stat_unused;

  assign stat_unused = ^stat_wdata[5:0];

  logic cpha, is_master, is_slave, ss_used, sel, tick, s_edge, ev;
  logic bit_in, sample, shift, done, in_byte, accept;

  assign cpha      = ~cke;
  assign is_master = en && (mode <= 4'd2);
  assign is_slave  = en && (mode == 4'd4 || mode == 4'd5);
  assign ss_used   = (mode == 4'd4);
  assign sel       = is_slave && !(ss_used && ss_n);
  assign half_m1   = (mode == 4'd0) ? PW'(HALF_FAST-1) :
                     (mode == 4'd1) ? PW'(HALF_MID-1) : PW'(HALF_SLOW-1);

  assign tick   = is_master && busy && !sleep && (presc == half_m1);
  assign s_edge = sel && (sck_sy[SYNC-1] != sck_d);
  assign ev     = tick || s_edge;
  assign n      = hc + EW'(1);
  assign last   = (is_master && cpha && smp) ? NEDGE + EW'(1) : NEDGE;
  assign bit_in = is_master ? sdi : sdi_sy[SYNC-1];
  assign sample = ev && (n[0] == ~(cpha ^ (is_master & smp)));
  assign shift  = ev && (n[0] == cpha) && (n >= EW'(2)) && (n < NEDGE);
  assign done   = ev && (n == last);
  assign rx_nxt = sample ? {rx[DW-2:0], bit_in} : rx;

  assign in_byte = is_master ? busy : (hc != '0);
  assign accept  = buf_we && !in_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0;
      sdi_sy <= '0;
      sck_d  <= 1'b0;
    end else begin
      sck_sy <= {sck_sy[SYNC-2:0], sck_i};
      sdi_sy <= {sdi_sy[SYNC-2:0], sdi};
      sck_d  <= sck_sy[SYNC-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc    <= '0;
      presc <= '0;
      busy  <= 1'b0;
    end else if (!en) begin
      hc    <= '0;
      presc <= '0;
      busy  <= 1'b0;
    end else begin
      if (is_slave && ss_used && ss_n) hc <= '0;
      else if (ev) hc <= done ? '0 : n;
      if (!busy) presc <= '0;
      else if (!sleep) presc <= tick ? '0 : presc + PW'(1);
      if (done) busy <= 1'b0;
      else if (accept && is_master) busy <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '0;
      rx <= '0;
    end else begin
      if (accept) tx <= buf_wdata;
      else if (shift) tx <= {tx[DW-2:0], 1'b0};
      rx <= rx_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {wcol, ovf, en, ckp, mode} <= '0;
      {smp, cke} <= '0;
      bf     <= 1'b0;
      buffer <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (ctrl_we) {wcol, ovf, en, ckp, mode} <= ctrl_wdata;
      if (stat_we) {smp, cke} <= stat_wdata[7:6];
      if (buf_we && in_byte) wcol <= 1'b1;
      if (buf_re) bf <= 1'b0;
      if (done) begin
        if (bf) ovf <= 1'b1;
        else begin
          buffer <= rx_nxt;
          bf <= 1'b1;
        end
      end
      if (irq_clr) irq_q <= 1'b0;
      if (done) irq_q <= 1'b1;
    end
  end

  assign ctrl_q    = {wcol, ovf, en, ckp, mode};
  assign stat_q    = {smp, cke, 5'b0, bf};
  assign buf_rdata = buffer;
  assign irq_flag  = irq_q;
  assign wake_req  = sleep && irq_en && irq_q;
  assign sck_o     = ckp ^ (is_master && busy && hc[0]);
  assign sck_oe    = is_master;
  assign sdo       = tx[DW-1];
  assign sdo_oe    = is_master || sel;

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && busy && sleep && !ctrl_we) |=> ($stable(sck_o) && $stable(sdo)));

  assert_overflow_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bf && !ctrl_we) |=> (ctrl_q[6] && $stable(buf_rdata)));

  assert_collision_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_we && is_master && busy) |=> ctrl_q[7]);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_re && !done) |=> !stat_q[0]);

  assert_deselect_resets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (is_slave && ss_used && ss_n) |=> (hc == '0));

  assert_edge_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (hc <= NEDGE));
endmodule

// File: tb/test_spi_port.sv
`timescale 1ns/1ps
module test_spi_port;
  logic clk = 0, rst_n = 0, sleep = 0;
  logic ctrl_we = 0, stat_we = 0, buf_we = 0, buf_re = 0, irq_en = 0, irq_clr = 0;
  logic [7:0] ctrl_wdata = 0, stat_wdata = 0, buf_wdata = 0;
  logic [7:0] ctrl_q, stat_q, buf_rdata;
  logic irq_flag, wake_req, sck_o, sck_oe, sdo, sdo_oe;
  logic sck_i = 0, ss_n = 1, sdi = 0;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  spi_port i_spi_port (
    .clk(clk), .rst_n(rst_n), .sleep(sleep),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_q(stat_q),
    .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_re(buf_re), .buf_rdata(buf_rdata),
    .irq_en(irq_en), .irq_clr(irq_clr), .irq_flag(irq_flag), .wake_req(wake_req),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .ss_n(ss_n),
    .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_wdata = v; ctrl_we = 1;
    @(negedge clk); ctrl_we = 0;
  endtask
  task automatic wr_stat(input logic [7:0] v);
    @(negedge clk); stat_wdata = v; stat_we = 1;
    @(negedge clk); stat_we = 0;
  endtask
  task automatic wr_buf(input logic [7:0] v);
    @(negedge clk); buf_wdata = v; buf_we = 1;
    @(negedge clk); buf_we = 0;
  endtask
  task automatic rd_and_clear();
    @(negedge clk); buf_re = 1; irq_clr = 1;
    @(negedge clk); buf_re = 0; irq_clr = 0;
    chk("R5 bf cleared by read", stat_q[0], 0);
    chk("R5 flag cleared", irq_flag, 0);
  endtask

  // opt: 0 plain, 1 sleep mid-byte, 2 collision write, 3 disable mid-byte
  task automatic master_xfer(input int mode, input bit ckp, input bit cke, input bit smp,
                             input logic [7:0] tx, input logic [7:0] y, input int opt);
    logic [7:0] got = 0;
    realtime t1 = 0, t2 = 0;
    bit cpha = !cke;
    int half = (mode == 0) ? 2 : (mode == 1) ? 8 : 32;
    logic s_sck, s_sdo;
    wr_ctrl({2'b00, 1'b1, ckp, 4'(mode)});
    wr_stat({smp, cke, 6'b0});
    sdi = smp ? ~y[7] : y[7];
    chk("R2 idle level", sck_o, ckp);
    chk("R13 master sck_oe", sck_oe, 1);
    chk("R13 master sdo_oe", sdo_oe, 1);
    wr_buf(tx);
    for (int e = 1; e <= 16; e++) begin
      @(sck_o); #1;
      if (e == 1) t1 = $realtime;
      if (e == 2) t2 = $realtime;
      if ((!cpha && e % 2 == 1) || (cpha && e % 2 == 0)) begin
        got = {got[6:0], sdo};
        if (smp) sdi = y[7 - (cpha ? e/2 - 1 : (e-1)/2)];
      end
      if (!smp && !cpha && e % 2 == 0 && e < 16) sdi = y[7 - e/2];
      if (!smp && cpha && e % 2 == 1 && e > 1) sdi = y[7 - (e-1)/2];
      if (opt == 1 && e == 5) begin
        sleep = 1; s_sck = sck_o; s_sdo = sdo;
        repeat (100) @(negedge clk);
        chk("R8 sck frozen", sck_o, s_sck);
        chk("R8 sdo frozen", sdo, s_sdo);
        chk("R8 no completion in sleep", irq_flag, 0);
        sleep = 0;
      end
      if (opt == 2 && e == 3) begin
        wr_buf(~tx);
        chk("R7 collision flag", ctrl_q[7], 1);
      end
      if (opt == 3 && e == 6) begin
        wr_ctrl({2'b00, 1'b0, ckp, 4'(mode)});
        repeat (200) @(negedge clk);
        chk("R12 no completion after abort", irq_flag, 0);
        chk("R12 sck_oe off", sck_oe, 0);
        chk("R12 sdo_oe off", sdo_oe, 0);
        return;
      end
    end
    while (!irq_flag) @(negedge clk);
    chk(smp ? "R3 late sample byte" : "R2 received byte", buf_rdata, y);
    chk(opt == 2 ? "R7 write ignored, mosi" : "R2 mosi msb first", got, tx);
    chk("R5 bf set", stat_q[0], 1);
    chk("R4 half period clocks", int'((t2 - t1) / 4.0), half);
    chk("R2 idle after byte", sck_o, ckp);
    rd_and_clear();
  endtask

  task automatic slave_xfer(input int mode, input bit ckp, input bit cke,
                            input logic [7:0] tx, input logic [7:0] m,
                            input int nbits, output logic [7:0] got);
    bit cpha = !cke;
    got = 0;
    @(negedge clk); sck_i = ckp; ss_n = 1;
    repeat (4) @(negedge clk);
    wr_ctrl({2'b00, 1'b1, ckp, 4'(mode)});
    wr_stat({1'b0, cke, 6'b0});
    wr_buf(tx);
    chk("R13 slave sck_oe off", sck_oe, 0);
    sdi = m[7];
    if (mode == 4) ss_n = 0;
    repeat (8) @(negedge clk);
    chk("R11 slave sdo_oe", sdo_oe, 1);
    for (int b = 0; b < nbits; b++) begin
      if (!cpha) got = {got[6:0], sdo}; else sdi = m[7-b];
      sck_i = ~ckp;
      repeat (8) @(negedge clk);
      if (cpha) got = {got[6:0], sdo}; else if (b < 7) sdi = m[6-b];
      sck_i = ckp;
      repeat (8) @(negedge clk);
    end
    ss_n = 1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] got, tx, y;
    int idx = 0;
    repeat (3) @(negedge clk);
    chk("R1 ctrl reset", ctrl_q, 0);
    chk("R1 stat reset", stat_q, 0);
    chk("R1 flag reset", irq_flag, 0);
    chk("R1 wake reset", wake_req, 0);
    chk("R1 sck_oe reset", sck_oe, 0);
    chk("R1 sdo_oe reset", sdo_oe, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int md = 0; md < 3; md++)
      for (int cp = 0; cp < 2; cp++)
        for (int ce = 0; ce < 2; ce++)
          for (int sm = 0; sm < 2; sm++) begin
            tx = 8'(8'h5A ^ (idx * 37));
            y  = 8'(idx * 73 + 11);
            master_xfer(md, cp[0], ce[0], sm[0], tx, y, 0);
            idx++;
          end

    master_xfer(1, 0, 1, 0, 8'hC3, 8'h96, 1);
    master_xfer(1, 1, 0, 1, 8'h3C, 8'h69, 1);
    master_xfer(1, 0, 0, 0, 8'hA5, 8'h0F, 2);
    master_xfer(1, 1, 1, 0, 8'h81, 8'h7E, 3);
    master_xfer(0, 1, 1, 0, 8'h18, 8'hE7, 0);

    for (int cp = 0; cp < 2; cp++)
      for (int ce = 0; ce < 2; ce++)
        for (int k = 0; k < 2; k++) begin
          tx = 8'(8'h33 + idx * 29);
          y  = 8'(8'hC1 ^ (idx * 53));
          slave_xfer(4, cp[0], ce[0], tx, y, 8, got);
          chk("R9 slave miso", got, tx);
          chk("R9 slave received", buf_rdata, y);
          chk("R9 slave completion", irq_flag, 1);
          chk("R11 sdo off when deselected", sdo_oe, 0);
          rd_and_clear();
          idx++;
        end

    slave_xfer(5, 0, 1, 8'h4D, 8'hB2, 8, got);
    chk("R11 mode5 ignores select, received", buf_rdata, 8'hB2);
    chk("R11 mode5 sdo_oe with select high", sdo_oe, 1);
    chk("R9 mode5 miso", got, 8'h4D);
    rd_and_clear();

    slave_xfer(4, 1, 0, 8'hF0, 8'h5C, 3, got);
    chk("R11 partial byte no completion", irq_flag, 0);
    chk("R11 sdo_oe off when deselected", sdo_oe, 0);
    slave_xfer(4, 1, 0, 8'h0F, 8'hA3, 8, got);
    chk("R11 counter reset, no collision", ctrl_q[7], 0);
    chk("R11 full byte after partial", buf_rdata, 8'hA3);
    chk("R11 miso after partial", got, 8'h0F);
    rd_and_clear();

    slave_xfer(4, 0, 1, 8'h11, 8'h22, 8, got);
    slave_xfer(4, 0, 1, 8'h44, 8'h88, 8, got);
    chk("R6 overflow flag", ctrl_q[6], 1);
    chk("R6 buffer keeps old byte", buf_rdata, 8'h22);
    rd_and_clear();

    irq_en = 1;
    sleep = 1;
    slave_xfer(4, 0, 0, 8'h6B, 8'hD4, 8, got);
    chk("R10 slave received in sleep", buf_rdata, 8'hD4);
    chk("R10 wake request", wake_req, 1);
    irq_en = 0; #1;
    chk("R10 no wake when disabled", wake_req, 0);
    irq_en = 1; sleep = 0; #1;
    chk("R10 no wake when awake", wake_req, 0);
    rd_and_clear();

    summary();
  end
endmodule